// File: doc/BRIEF.md
# ADC Serial Output Formatter

This block sits between the two conversion channels of a dual 14-bit converter and its serial output pins. For each channel it chooses what is sent (the live sample, a fixed test word, or a test word written by software) and converts live data to two's complement or offset binary. It then shifts the word out on one lane or on two lanes. Every output word spans a 14-clock frame, and a frame marker is high on the first bit of each frame.

The control register, the two user-pattern registers and the sample words are taken as inputs that are already settled. A sample is captured when the valid strobe is high. The held sample, the source selection and the format are sampled once per frame, on the last clock of the frame. Lane count, lane skew and power-down act on the lanes at once.

Top module: `adc_serial_fmt`

## Requirements
- R1: During reset and just after it, the frame marker is high, every lane outputs 0, and with the reset control value 0x08 both low-lane enables are 1.
- R2: The frame marker is high for one clock in every 14, on the first bit of each word. A new word is loaded on the clock edge that ends the previous frame.
- R3: In control bits [7:6] mode 00 and mode 11, live samples are sent. If control bit 3 is 1, the sample passes unchanged (two's complement). If it is 0, the sample MSB is inverted (offset binary).
- R4: Mode 01 sends the constant word 14'b10100110001110 whatever the value of bit 3.
- R5: Mode 10 sends the user word {upat_hi[5:0], upat_lo[7:0]} without format conversion.
- R6: When control bit 5 is 1 (single lane), the high lane sends bits 13 down to 0, one bit per clock, starting at the frame marker. The low lane is 0 and its enable is 0.
- R7: When bit 5 is 0 (dual lane), the high lane sends bits 13..7 and the low lane sends bits 6..0, each MSB first, each bit held for two clocks. The low-lane enable is 1.
- R8: In dual lane with control bit 2 at 1, the high lane carries the same bit stream delayed by one clock. The low lane keeps its timing.
- R9: In single lane, control bit 2 has no effect.
- R10: Control bit 1 forces both lanes of channel A (index 0) to 0. Bit 0 does the same for channel B (index 1). The other channel is unaffected.
- R11: A sample is captured only while samp_valid is high. Sample changes without the strobe do not reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_reg | input | 8 | Control register value |
| upat_hi | input | 6 | User word bits 13:8 |
| upat_lo | input | 8 | User word bits 7:0 |
| samp_valid | input | 1 | Sample strobe for both channels |
| samp_a | input | 14 | Channel A sample, two's complement |
| samp_b | input | 14 | Channel B sample, two's complement |
| lane_hi | output | 2 | High lane per channel (index 0 = A) |
| lane_lo | output | 2 | Low lane per channel |
| lane_lo_oe | output | 2 | Low-lane drive enable per channel |
| frame | output | 1 | First-bit marker of each word |

## Verification
A sample strobe can arrive in the same clock as the end-of-frame word load. The load must take the sample held before that edge, and the new sample must go into the following word. The bench raises the strobe with a new value exactly in the last clock of a frame. It then expects the frame that follows to carry the old value and the next frame to carry the new one, on both channels.

// File: rtl/adc_sfmt_pkg.sv
package adc_sfmt_pkg;
  localparam int WORD_W = 14;
  localparam logic [WORD_W-1:0] FIXED_WORD = 14'b10100110001110;

  typedef enum logic [1:0] {
    SRC_LIVE  = 2'b00,
    SRC_FIXED = 2'b01,
    SRC_USER  = 2'b10,
    SRC_RSVD  = 2'b11
  } src_e;

  typedef struct packed {
    src_e src;
    logic single;
    logic stab;
    logic twos;
    logic skew;
    logic off_a;
    logic off_b;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] fmt_live(input logic [WORD_W-1:0] s, input logic twos);
    fmt_live = twos ? s : {~s[WORD_W-1], s[WORD_W-2:0]};
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input src_e src, input logic twos,
                                                  input logic [WORD_W-1:0] s,
                                                  input logic [WORD_W-1:0] u);
    case (src)
      SRC_FIXED: pick_word = FIXED_WORD;
      SRC_USER:  pick_word = u;
      default:   pick_word = fmt_live(s, twos);
    endcase
  endfunction
endpackage

// File: rtl/adc_sfmt_phase.sv
module adc_sfmt_phase #(
  parameter int W = 14,
  localparam int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          frame,
  output logic          load
);
  localparam logic [PW-1:0] LAST = PW'(W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                  phase <= phase + 1'b1;
  end

  assign frame = (phase == '0);
  assign load  = (phase == LAST);
endmodule

// File: rtl/adc_sfmt_src.sv
module adc_sfmt_src
  import adc_sfmt_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         valid,
  input  logic [W-1:0] sample,
  input  src_e         src,
  input  logic         twos,
  input  logic [W-1:0] upat,
  output logic [W-1:0] word
);
  logic [W-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      word <= '0;
    end else begin
      if (valid) hold <= sample;
      if (load)  word <= pick_word(src, twos, hold, upat);
    end
  end
endmodule

// File: rtl/adc_sfmt_ser.sv
module adc_sfmt_ser #(
  parameter int W = 14,
  localparam int PW = $clog2(W),
  localparam int HALF = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word,
  input  logic [PW-1:0] phase,
  input  logic          single,
  input  logic          skew,
  input  logic          off,
  output logic          hi_raw,
  output logic          hi,
  output logic          lo,
  output logic          lo_oe
);
  localparam logic [PW-1:0] TOP = PW'(W - 1);
  localparam logic [PW-1:0] MID = PW'(HALF - 1);

  logic [PW-1:0] slot;
  logic          lo_bit;
  logic          hi_dly;
  logic          use_skew;

  assign slot = phase >> 1;

  always_comb begin
    if (single) begin
      hi_raw = word[TOP - phase];
      lo_bit = 1'b0;
    end else begin
      hi_raw = word[TOP - slot];
      lo_bit = word[MID - slot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_dly <= 1'b0;
    else        hi_dly <= hi_raw;
  end

  assign use_skew = skew & ~single;
  assign hi    = off ? 1'b0 : (use_skew ? hi_dly : hi_raw);
  assign lo    = (off | single) ? 1'b0 : lo_bit;
  assign lo_oe = ~single;
endmodule

// File: rtl/adc_serial_fmt.sv
module adc_serial_fmt
  import adc_sfmt_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int CH = 2,
  localparam int PW = $clog2(W),
  localparam int UHI = W - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    ctrl_reg,
  input  logic [UHI-1:0] upat_hi,
  input  logic [7:0]    upat_lo,
  input  logic          samp_valid,
  input  logic [W-1:0]  samp_a,
  input  logic [W-1:0]  samp_b,
  output logic [CH-1:0] lane_hi,
  output logic [CH-1:0] lane_lo,
  output logic [CH-1:0] lane_lo_oe,
  output logic          frame
);
  ctrl_t         cfg;
  logic [PW-1:0] phase;
  logic          load_evt;
  logic [W-1:0]  upat;
  logic [W-1:0]  samp   [CH];
  logic [CH-1:0] off_ch;
  logic [CH-1:0] hi_raw_w;
  logic          stab_unused;

  assign cfg  = ctrl_t'(ctrl_reg);
  assign upat = {upat_hi, upat_lo};
  assign samp[0] = samp_a;
  assign samp[1] = samp_b;
  assign off_ch  = {cfg.off_b, cfg.off_a};
  assign stab_unused = cfg.stab;

  adc_sfmt_phase #(.W(W)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .frame(frame), .load(load_evt)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [W-1:0] word;

    adc_sfmt_src #(.W(W)) u_src (
      .clk(clk), .rst_n(rst_n), .load(load_evt), .valid(samp_valid),
      .sample(samp[c]), .src(cfg.src), .twos(cfg.twos), .upat(upat), .word(word)
    );

    adc_sfmt_ser #(.W(W)) u_ser (
      .clk(clk), .rst_n(rst_n), .word(word), .phase(phase),
      .single(cfg.single), .skew(cfg.skew), .off(off_ch[c]),
      .hi_raw(hi_raw_w[c]), .hi(lane_hi[c]), .lo(lane_lo[c]), .lo_oe(lane_lo_oe[c])
    );
  end
endmodule

// File: rtl/adc_serial_fmt_chk.sv
module adc_serial_fmt_chk #(
  parameter int W = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_reg,
  input logic       frame,
  input logic       load_evt,
  input logic [1:0] hi_raw_w,
  input logic [1:0] lane_hi,
  input logic [1:0] lane_lo,
  input logic [1:0] lane_lo_oe
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (frame) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  a_r2_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && seen) |-> (gap == 8'(W - 1)));

  a_r2_load_then_frame: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> frame);

  a_r6_single_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[5] |-> (lane_lo_oe == 2'b00 && lane_lo == 2'b00));

  a_r7_dual_lo_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_reg[5] |-> (lane_lo_oe == 2'b11));

  a_r8_skew_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_reg[5] && ctrl_reg[2] && !ctrl_reg[1]) |-> (lane_hi[0] == $past(hi_raw_w[0])));

  a_r8_skew_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_reg[5] && ctrl_reg[2] && !ctrl_reg[0]) |-> (lane_hi[1] == $past(hi_raw_w[1])));

  a_r10_off_a: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[1] |-> (lane_hi[0] == 1'b0 && lane_lo[0] == 1'b0));

  a_r10_off_b: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[0] |-> (lane_hi[1] == 1'b0 && lane_lo[1] == 1'b0));
endmodule

bind adc_serial_fmt adc_serial_fmt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg), .frame(frame),
  .load_evt(load_evt), .hi_raw_w(hi_raw_w), .lane_hi(lane_hi),
  .lane_lo(lane_lo), .lane_lo_oe(lane_lo_oe)
);

// File: tb/adc_serial_fmt_bench.sv
module adc_serial_fmt_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctrl_reg = 8'h08;
  logic [5:0]  upat_hi = '0;
  logic [7:0]  upat_lo = '0;
  logic        samp_valid = 1'b0;
  logic [13:0] samp_a = '0;
  logic [13:0] samp_b = '0;
  logic [1:0]  lane_hi, lane_lo, lane_lo_oe;
  logic        frame;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_fmt u_adc_serial_fmt (
    .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg), .upat_hi(upat_hi),
    .upat_lo(upat_lo), .samp_valid(samp_valid), .samp_a(samp_a), .samp_b(samp_b),
    .lane_hi(lane_hi), .lane_lo(lane_lo), .lane_lo_oe(lane_lo_oe), .frame(frame)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] expect_word(input logic [7:0] c, input logic [13:0] s);
    logic [13:0] u;
    u = {upat_hi, upat_lo};
    if (c[7:6] == 2'b01)      return 14'h298E;
    else if (c[7:6] == 2'b10) return u;
    else if (c[3])            return s;
    else                      return s ^ 14'h2000;
  endfunction

  task automatic wait_frame();
    @(negedge clk);
    while (!frame) @(negedge clk);
  endtask

  // Starts at a negedge where frame is high; checks all 14 clocks.
  task automatic check_here(input logic [13:0] wa, input logic [13:0] wb, input string req);
    logic [13:0] w;
    logic single, skew, off;
    single = ctrl_reg[5];
    skew   = ctrl_reg[2] & ~single;
    for (int k = 0; k < 14; k++) begin
      if (k != 0) @(negedge clk);
      check({req, " frame"}, 32'(frame), 32'(k == 0));
      for (int c = 0; c < 2; c++) begin
        w   = (c == 0) ? wa : wb;
        off = (c == 0) ? ctrl_reg[1] : ctrl_reg[0];
        check({req, " oe"}, 32'(lane_lo_oe[c]), 32'(!single));
        if (single) begin
          check({req, " hi"}, 32'(lane_hi[c]), off ? 0 : 32'(w[13-k]));
          check({req, " lo"}, 32'(lane_lo[c]), 0);
        end else begin
          if (!skew)
            check({req, " hi"}, 32'(lane_hi[c]), off ? 0 : 32'(w[13-k/2]));
          else if (k != 0)
            check({req, " hi"}, 32'(lane_hi[c]), off ? 0 : 32'(w[13-(k-1)/2]));
          check({req, " lo"}, 32'(lane_lo[c]), off ? 0 : 32'(w[6-k/2]));
        end
      end
    end
  endtask

  task automatic run_word(input logic [7:0] c, input logic [13:0] a, input logic [13:0] b,
                          input string req);
    @(negedge clk);
    ctrl_reg = c; samp_a = a; samp_b = b; samp_valid = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
    wait_frame();
    wait_frame();
    check_here(expect_word(c, a), expect_word(c, b), req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 frame", 32'(frame), 1);
    check("R1 hi", 32'(lane_hi), 0);
    check("R1 lo", 32'(lane_lo), 0);
    check("R1 oe", 32'(lane_lo_oe), 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 lanes after", 32'({lane_hi, lane_lo}), 0);
  endtask

  task automatic t_no_strobe();
    run_word(8'h08, 14'h0F0F, 14'h30C3, "R11 base");
    @(negedge clk);
    samp_a = 14'h1111; samp_b = 14'h2222;
    wait_frame();
    wait_frame();
    check_here(14'h0F0F, 14'h30C3, "R11 no strobe");
  endtask

  task automatic t_collide();
    run_word(8'h08, 14'h0ABC, 14'h1DEF, "R2 collide base");
    wait_frame();
    repeat (13) @(negedge clk);
    samp_a = 14'h3456; samp_b = 14'h0789; samp_valid = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
    check_here(14'h0ABC, 14'h1DEF, "R2 R11 collide old");
    wait_frame();
    check_here(14'h3456, 14'h0789, "R2 R11 collide new");
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_word(8'h08, 14'h2A5C, 14'h1357, "R3 R7 twos");
        run_word(8'h00, 14'h2A5C, 14'h1357, "R3 offset");
        run_word(8'hC0, 14'h0001, 14'h3FFE, "R3 mode11");
        run_word(8'h48, 14'h1234, 14'h0000, "R4 fixed twos");
        run_word(8'h40, 14'h1234, 14'h0000, "R4 fixed offset");
        upat_hi = 6'h2D; upat_lo = 8'hB4;
        run_word(8'h80, 14'h0000, 14'h3FFF, "R5 user");
        run_word(8'h28, 14'h2C71, 14'h138E, "R6 single");
        run_word(8'h2C, 14'h2C71, 14'h138E, "R9 single skew bit");
        run_word(8'h0C, 14'h2C71, 14'h138E, "R8 dual skew");
        run_word(8'h0A, 14'h3FFF, 14'h3FFF, "R10 off A");
        run_word(8'h29, 14'h3FFF, 14'h2AAA, "R10 off B single");
        t_no_strobe();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule